// File: doc/BRIEF.md
# Dual Condition-Flag Branch and Select Unit

This block holds the condition state and the control-transfer sequencing of a small two-way pipelined processor. It keeps two condition flags that can be addressed one by one. A compare operation (subtract and set) records whether its two operands differ in the flag it names. A conditional move picks one of two operands according to the flag it names. A conditional jump tests a named flag, and an unconditional jump is always taken. Because the flags are separate, a loop-exit test can run on one flag while a data-dependent select runs on the other. The select can then fill the branch delay slot.

Every issue cycle presents one bundle of up to two decoded micro-ops, together with the program counter of that bundle. Any flag read inside a bundle sees the value from before the bundle. Flag writes made by the bundle become visible to the next bundle. A taken jump redirects fetch only after its single delay-slot bundle has issued.

A three-state sequencer controls the redirect:
- ST_IDLE: no transfer is pending.
- ST_SLOT: a jump was taken and the unit is waiting for the delay-slot bundle.
- ST_RDR: the redirect is presented for one cycle.

Its transitions are:
- IDLE→SLOT: a taken jump issues.
- IDLE→IDLE: no taken jump issues.
- SLOT→RDR: any bundle issues, and that bundle is the delay slot.
- SLOT→SLOT: the issue stalls.
- RDR→SLOT: another taken jump issues.
- RDR→IDLE: no taken jump issues.

Top module: `cc_branch_unit`

## Requirements
- R1: After reset both flags read 0 and `redirect` is 0.
- R2: A SETCC micro-op (code 1) in an issued bundle writes 1 into the flag named by its `fsel` field if its source A differs from its source B, and 0 otherwise. The new value shows on `flags` after the next clock edge. A flag that no slot writes keeps its value.
- R3: For a CMOV micro-op (code 2), the slot's `cmov_res` lane shows source A when the named flag is 1 and source B when it is 0. The flag value used is the one from before the bundle, even if the same bundle writes that flag. For any other code the lane is 0.
- R4: If both slots of one bundle write the same flag with SETCC, the value from slot 1 is kept.
- R5: A JCC micro-op (code 3) is taken only when its named flag, as it was before the bundle, is 1. A JMP micro-op (code 4) is always taken. Code 0 is a NOP. A JCC that is not taken never causes a redirect.
- R6: After a taken jump, `redirect` is high for exactly one cycle. That cycle is the one that follows the issue of the next bundle. `redirect_pc` then equals the `cur_pc` of the jump's bundle plus the jump slot's `br_off`.
- R7: The bundle in the delay slot always executes. A CMOV in it that reads flag 1 sees flag 1's own value, whatever flag 0 held when a JCC tested it.
- R8: A jump placed in the delay slot has no effect. Neither the pending target nor the single redirect changes.
- R9: If both slots of one bundle hold a taken jump, slot 0's target is used.
- R10: While `issue` is 0, the flags keep their values, no jump is accepted, and a pending delay slot stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue | input | 1 | A bundle issues this cycle |
| op | input | NSLOT*3 | Micro-op code for each slot (slot s at bits 3s+2:3s) |
| fsel | input | NSLOT*FW | Flag index for each slot |
| src_a | input | NSLOT*DW | Source A for each slot |
| src_b | input | NSLOT*DW | Source B for each slot |
| br_off | input | NSLOT*AW | Jump offset for each slot |
| cur_pc | input | AW | PC of the issuing bundle |
| flags | output | NFLAG | Current flag values |
| cmov_res | output | NSLOT*DW | Conditional-move result for each slot |
| redirect | output | 1 | Fetch redirect request |
| redirect_pc | output | AW | Redirect target address |

## Verification
The hardest case to reach is a delay slot that arrives late or is itself a jump. For that, a taken jump must be followed by zero, one or two stalled cycles, and the delay-slot bundle must then hold both a jump that has to be ignored and a select on the other flag. The bench builds these from a jump sweep over every flag value, jump slot, tested flag and stall length. It presets the flags to opposite values, so that a select which wrongly read the jump's flag would return the other operand.

// File: rtl/cc_unit_pkg.sv
package cc_unit_pkg;
    localparam int OPW = 3;

    typedef enum logic [2:0] {
        OP_NOP   = 3'd0,
        OP_SETCC = 3'd1,
        OP_CMOV  = 3'd2,
        OP_JCC   = 3'd3,
        OP_JMP   = 3'd4
    } uop_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SLOT = 2'd1,
        ST_RDR  = 2'd2
    } seq_e;
endpackage

// File: rtl/cc_flag_bank.sv
module cc_flag_bank
    import cc_unit_pkg::*;
#(
    parameter int NSLOT = 2,
    parameter int NFLAG = 2,
    parameter int FW    = 1,
    parameter int DW    = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 issue,
    input  logic [NSLOT*OPW-1:0] op,
    input  logic [NSLOT*FW-1:0]  fsel,
    input  logic [NSLOT*DW-1:0]  src_a,
    input  logic [NSLOT*DW-1:0]  src_b,
    output logic [NFLAG-1:0]     flags
);
    logic [NSLOT-1:0] wr_en;
    logic [NSLOT-1:0] wr_val;
    logic [FW-1:0]    wr_idx [NSLOT];
    logic [NFLAG-1:0] flags_q;
    logic [NFLAG-1:0] flags_d;

    for (genvar s = 0; s < NSLOT; s++) begin : g_wr
        assign wr_en[s]  = issue && (op[s*OPW +: OPW] == OP_SETCC);
        assign wr_idx[s] = fsel[s*FW +: FW];
        assign wr_val[s] = (src_a[s*DW +: DW] != src_b[s*DW +: DW]);
    end

    // later slots override earlier ones
    always_comb begin
        flags_d = flags_q;
        for (int s = 0; s < NSLOT; s++) begin
            if (wr_en[s] && (int'(wr_idx[s]) < NFLAG)) begin
                flags_d[wr_idx[s]] = wr_val[s];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign flags = flags_q;

    AST_FLAGS_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !issue |=> $stable(flags)); // R10

    AST_LAST_SLOT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en[NSLOT-1] |=> flags[$past(wr_idx[NSLOT-1])] == $past(wr_val[NSLOT-1])); // R4
endmodule

// File: rtl/cc_select_lane.sv
module cc_select_lane
    import cc_unit_pkg::*;
#(
    parameter int NFLAG = 2,
    parameter int FW    = 1,
    parameter int DW    = 32
) (
    input  logic [NFLAG-1:0] flags,
    input  logic [OPW-1:0]   op,
    input  logic [FW-1:0]    fsel,
    input  logic [DW-1:0]    src_a,
    input  logic [DW-1:0]    src_b,
    output logic [DW-1:0]    res
);
    logic cond;

    always_comb begin
        cond = 1'b0;
        if (int'(fsel) < NFLAG) cond = flags[fsel];
    end

    always_comb begin
        res = '0;
        if (op == OP_CMOV) res = cond ? src_a : src_b;
    end
endmodule

// File: rtl/br_delay_fsm.sv
module br_delay_fsm
    import cc_unit_pkg::*;
#(
    parameter int NSLOT = 2,
    parameter int NFLAG = 2,
    parameter int FW    = 1,
    parameter int AW    = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 issue,
    input  logic [NFLAG-1:0]     flags,
    input  logic [NSLOT*OPW-1:0] op,
    input  logic [NSLOT*FW-1:0]  fsel,
    input  logic [NSLOT*AW-1:0]  br_off,
    input  logic [AW-1:0]        cur_pc,
    output logic                 redirect,
    output logic [AW-1:0]        redirect_pc
);
    seq_e             state, state_d;
    logic [AW-1:0]    tgt_q;
    logic [NSLOT-1:0] taken;
    logic             hit;
    logic [AW-1:0]    hit_tgt;
    logic             load;

    for (genvar s = 0; s < NSLOT; s++) begin : g_take
        logic [FW-1:0] idx;
        logic          cond;
        assign idx  = fsel[s*FW +: FW];
        assign cond = (int'(idx) < NFLAG) ? flags[idx] : 1'b0;
        assign taken[s] = issue &&
            ((op[s*OPW +: OPW] == OP_JMP) ||
             ((op[s*OPW +: OPW] == OP_JCC) && cond));
    end

    // lowest-numbered taken slot supplies the target
    always_comb begin
        hit     = 1'b0;
        hit_tgt = '0;
        for (int s = NSLOT - 1; s >= 0; s--) begin
            if (taken[s]) begin
                hit     = 1'b1;
                hit_tgt = cur_pc + br_off[s*AW +: AW];
            end
        end
    end

    always_comb begin
        state_d = state;
        load    = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (hit) begin
                    state_d = ST_SLOT;
                    load    = 1'b1;
                end
            end
            ST_SLOT: begin
                if (issue) state_d = ST_RDR;
            end
            ST_RDR: begin
                if (hit) begin
                    state_d = ST_SLOT;
                    load    = 1'b1;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            tgt_q <= '0;
        end else begin
            state <= state_d;
            if (load) tgt_q <= hit_tgt;
        end
    end

    always_comb begin
        redirect    = (state == ST_RDR);
        redirect_pc = tgt_q;
    end

    AST_RDR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |=> !redirect); // R6

    AST_RDR_AFTER_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |-> $past(issue)); // R6

    AST_TGT_HELD_IN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLOT) |=> $stable(redirect_pc)); // R8

    AST_STALL_KEEPS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLOT && !issue) |=> (state == ST_SLOT)); // R10
endmodule

// File: rtl/cc_branch_unit.sv
module cc_branch_unit
    import cc_unit_pkg::*;
#(
    parameter int NSLOT = 2,
    parameter int NFLAG = 2,
    parameter int DW    = 32,
    parameter int AW    = 32,
    localparam int FW   = (NFLAG > 1) ? $clog2(NFLAG) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 issue,
    input  logic [NSLOT*3-1:0]   op,
    input  logic [NSLOT*FW-1:0]  fsel,
    input  logic [NSLOT*DW-1:0]  src_a,
    input  logic [NSLOT*DW-1:0]  src_b,
    input  logic [NSLOT*AW-1:0]  br_off,
    input  logic [AW-1:0]        cur_pc,
    output logic [NFLAG-1:0]     flags,
    output logic [NSLOT*DW-1:0]  cmov_res,
    output logic                 redirect,
    output logic [AW-1:0]        redirect_pc
);
    logic [NFLAG-1:0] flags_w;

    cc_flag_bank #(.NSLOT(NSLOT), .NFLAG(NFLAG), .FW(FW), .DW(DW)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .issue (issue),
        .op    (op),
        .fsel  (fsel),
        .src_a (src_a),
        .src_b (src_b),
        .flags (flags_w)
    );

    for (genvar s = 0; s < NSLOT; s++) begin : g_lane
        cc_select_lane #(.NFLAG(NFLAG), .FW(FW), .DW(DW)) u_sel (
            .flags (flags_w),
            .op    (op[s*OPW +: OPW]),
            .fsel  (fsel[s*FW +: FW]),
            .src_a (src_a[s*DW +: DW]),
            .src_b (src_b[s*DW +: DW]),
            .res   (cmov_res[s*DW +: DW])
        );
    end

    br_delay_fsm #(.NSLOT(NSLOT), .NFLAG(NFLAG), .FW(FW), .AW(AW)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .issue       (issue),
        .flags       (flags_w),
        .op          (op),
        .fsel        (fsel),
        .br_off      (br_off),
        .cur_pc      (cur_pc),
        .redirect    (redirect),
        .redirect_pc (redirect_pc)
    );

    assign flags = flags_w;
endmodule

// File: tb/cc_branch_unit_test.sv
module cc_branch_unit_test;
    localparam int NS = 2;
    localparam int DW = 32;
    localparam int AW = 32;
    localparam logic [2:0] NOP = 3'd0, SET = 3'd1, CMV = 3'd2, JCC = 3'd3, JMP = 3'd4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              issue = 1'b0;
    logic [NS*3-1:0]   op = '0;
    logic [NS-1:0]     fsel = '0;
    logic [NS*DW-1:0]  src_a = '0;
    logic [NS*DW-1:0]  src_b = '0;
    logic [NS*AW-1:0]  br_off = '0;
    logic [AW-1:0]     cur_pc = '0;
    logic [1:0]        flags;
    logic [NS*DW-1:0]  cmov_res;
    logic              redirect;
    logic [AW-1:0]     redirect_pc;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [1:0]  mf = 2'b00;
    int          mst = 0;       // 0 idle, 1 awaiting slot, 2 redirect
    logic [31:0] mtgt = '0;

    always #2 clk = ~clk;

    cc_branch_unit uut (
        .clk(clk), .rst_n(rst_n), .issue(issue), .op(op), .fsel(fsel),
        .src_a(src_a), .src_b(src_b), .br_off(br_off), .cur_pc(cur_pc),
        .flags(flags), .cmov_res(cmov_res), .redirect(redirect),
        .redirect_pc(redirect_pc)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input bit iss,
                        input logic [2:0] o0, input logic f0, input logic [31:0] a0, input logic [31:0] b0, input logic [31:0] d0,
                        input logic [2:0] o1, input logic f1, input logic [31:0] a1, input logic [31:0] b1, input logic [31:0] d1,
                        input logic [31:0] pc, input string tf, input string tc);
        logic [1:0]  nf;
        logic [31:0] e0, e1;
        bit          t0, t1, hit;
        logic [31:0] ht;
        @(negedge clk);
        issue = iss; op = {o1, o0}; fsel = {f1, f0};
        src_a = {a1, a0}; src_b = {b1, b0}; br_off = {d1, d0}; cur_pc = pc;
        #1;
        e0 = (o0 == CMV) ? (mf[f0] ? a0 : b0) : 32'd0;
        e1 = (o1 == CMV) ? (mf[f1] ? a1 : b1) : 32'd0;
        chk(cmov_res[31:0] == e0, tc, cmov_res[31:0], e0);
        chk(cmov_res[63:32] == e1, tc, cmov_res[63:32], e1);
        nf = mf;
        if (iss && o0 == SET) nf[f0] = (a0 != b0);
        if (iss && o1 == SET) nf[f1] = (a1 != b1);
        t0 = iss && (o0 == JMP || (o0 == JCC && mf[f0]));
        t1 = iss && (o1 == JMP || (o1 == JCC && mf[f1]));
        hit = t0 || t1;
        ht  = t0 ? pc + d0 : pc + d1;
        @(posedge clk);
        #1;
        mf = nf;
        case (mst)
            0: if (hit) begin mst = 1; mtgt = ht; end
            1: if (iss) mst = 2;
            default: if (hit) begin mst = 1; mtgt = ht; end else mst = 0;
        endcase
        chk(flags == mf, tf, {30'd0, flags}, {30'd0, mf});
        chk(redirect == (mst == 2), tf, {31'd0, redirect}, {31'd0, (mst == 2)});
        if (mst == 2) chk(redirect_pc == mtgt, "R6", redirect_pc, mtgt);
    endtask

    task automatic preset(input logic [1:0] v);
        step(1, SET, 1'b0, {31'd0, v[0]}, 0, 0, SET, 1'b1, {31'd0, v[1]}, 0, 0, 0, "R2", "R3");
    endtask

    task automatic idle_cyc(input string tag);
        step(0, NOP, 0, 0, 0, 0, NOP, 0, 0, 0, 0, 0, tag, "R3");
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk(flags == 2'b00, "R1", {30'd0, flags}, 0);
        chk(redirect == 1'b0, "R1", {31'd0, redirect}, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // flag write / select sweep: R2 R3 R4
        for (int init = 0; init < 4; init++) begin
            for (int p0 = 0; p0 < 2; p0++) begin
                for (int p1 = 0; p1 < 2; p1++) begin
                    for (int g0 = 0; g0 < 2; g0++) begin
                        for (int g1 = 0; g1 < 2; g1++) begin
                            for (int eq = 0; eq < 4; eq++) begin
                                logic [2:0] c0, c1;
                                string tg;
                                c0 = p0 ? CMV : SET;
                                c1 = p1 ? CMV : SET;
                                tg = (c0 == SET && c1 == SET && g0 == g1) ? "R4" : "R2";
                                preset(init[1:0]);
                                step(1, c0, g0[0], 100, eq[0] ? 100 : 7, 0,
                                        c1, g1[0], 55, eq[1] ? 55 : 9, 0, 0, tg, "R3");
                            end
                        end
                    end
                end
            end
        end

        // stalled bundle must not write: R10
        preset(2'b01);
        step(0, SET, 1'b0, 0, 0, 0, SET, 1'b1, 3, 4, 0, 0, "R10", "R3");

        // conditional jump sweep with delay slot: R5 R6 R7 R8
        for (int fv = 0; fv < 2; fv++) begin
            for (int js = 0; js < 2; js++) begin
                for (int fl = 0; fl < 2; fl++) begin
                    for (int st = 0; st < 3; st++) begin
                        logic [1:0] pv;
                        logic [2:0] q0, q1;
                        pv = '0;
                        pv[fl]     = fv[0];
                        pv[1 - fl] = ~fv[0];
                        preset(pv);
                        q0 = (js == 0) ? JCC : CMV;
                        q1 = (js == 1) ? JCC : CMV;
                        step(1, q0, (js == 0) ? fl[0] : ~fl[0], 11, 22, 16,
                                q1, (js == 1) ? fl[0] : ~fl[0], 11, 22, 20,
                                32'h1000 + 32'(st * 64), "R5", "R7");
                        for (int k = 0; k < st; k++) idle_cyc("R10");
                        // delay slot: ignored jump plus select on the other flag
                        step(1, JMP, 1'b0, 0, 0, 32'h40, CMV, ~fl[0], 33, 44, 0,
                                32'h2000, "R8", "R7");
                        idle_cyc("R6");
                        idle_cyc("R6");
                    end
                end
            end
        end

        // both slots jump: R9
        step(1, JMP, 0, 0, 0, 32'h100, JMP, 0, 0, 0, 32'h200, 32'h4000, "R9", "R3");
        step(1, NOP, 0, 0, 0, 0, NOP, 0, 0, 0, 0, 0, "R9", "R3");
        idle_cyc("R9");

        // back-to-back: jump issued in the redirect cycle is accepted
        step(1, JMP, 0, 0, 0, 32'h8, NOP, 0, 0, 0, 0, 32'h500, "R6", "R3");
        step(1, NOP, 0, 0, 0, 0, NOP, 0, 0, 0, 0, 0, "R6", "R3");
        step(1, NOP, 0, 0, 0, 0, JMP, 0, 0, 0, 32'hC, 32'h600, "R6", "R3");
        step(1, NOP, 0, 0, 0, 0, NOP, 0, 0, 0, 0, 0, "R6", "R3");
        idle_cyc("R6");
        idle_cyc("R6");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule